// File: doc/BRIEF.md
# Stop-State Oscillator Demand Arbiter

While the system sits in its stop state, several wakeup-capable serial receivers (I2C, UART and a low-power UART) may each need the shared 16 MHz internal oscillator for the length of one incoming frame. This block collects their demand lines. It switches the oscillator on while at least one receiver asks for it, and it passes the oscillator clock only to the receivers that asked. When the last demand is withdrawn and the system is still stopped, the oscillator is switched off again. This covers the case of a frame that turned out not to be a wakeup frame.

A receiver that recognises a valid wakeup frame pulses its wake line. The block then raises a wakeup request to the power controller, and the request stays up until the stop state is left. Outside the stop state all demand lines are ignored, every gated output stays low, and the oscillator enable follows the run-mode clock setting. Each per-receiver gate opens only after the oscillator reports ready. A gate changes only during the low phase of the oscillator clock, so every gated pulse is a whole oscillator high phase.

All control inputs are synchronous to `clk`. The `osc_clk` input is the free oscillator output. Each gate enable crosses into that domain through two flops and is then applied on its falling edge.

Top module: `osc_demand_arbiter`

## Requirements
- R1: After reset, `osc_en`, `wakeup` and every bit of `gclk` are low.
- R2: While `stop_mode` is high, `osc_en` is high one `clk` cycle after any bit of `req` is high.
- R3: While `stop_mode` is high, `osc_en` stays high as long as any request remains. It drops one `clk` cycle after the last request clears.
- R4: In the stop state with `osc_rdy` high, `gclk[i]` carries oscillator pulses only for a requester i whose `req[i]` is high. Every other `gclk` bit stays low.
- R5: While `osc_rdy` is low, no `gclk` bit pulses, even when requests are pending.
- R6: Every high pulse on a `gclk` bit lasts exactly one high phase of `osc_clk`. No gate opens or closes while `osc_clk` is high.
- R7: In the stop state, `wakeup` goes high one cycle after `wake_frame[i]` is high together with `req[i]`, and it stays high while `stop_mode` remains high. A `wake_frame[i]` pulse without `req[i]` does not set `wakeup`.
- R8: `wakeup` is low one cycle after `stop_mode` is low.
- R9: While `stop_mode` is low, `osc_en` equals the `run_osc_en` value from one cycle earlier. Requests do not affect `osc_en`, and no `gclk` bit pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_mode | input | 1 | High while the system is in the stop state |
| run_osc_en | input | 1 | Run-mode oscillator enable from the clock configuration |
| osc_rdy | input | 1 | Oscillator output is stable |
| req | input | N_REQ | Per-receiver oscillator demand |
| wake_frame | input | N_REQ | Per-receiver pulse: the received frame is a wakeup frame |
| osc_clk | input | 1 | Oscillator clock output |
| osc_en | output | 1 | Oscillator enable |
| wakeup | output | 1 | Wakeup request to the power controller |
| gclk | output | N_REQ | Per-receiver gated oscillator clock |

## Verification
The main function is tried in several patterns: one requester alone, two requesters together, the same demand with the ready flag low, and requesters released one at a time. Together these separate a per-requester gate from a global one, show that the gate depends on the ready flag, and show that the enable follows the OR of all demands and not the last one seen. Wake pulses come both from a requesting and from a non-requesting receiver, to show that only a requester's frame counts. A run-mode pass shows that demand is ignored there. Each gated pulse is timed, so a gate that changes during the high phase is caught.

// File: rtl/osc_arb_pkg.sv
package osc_arb_pkg;

    // Default number of receivers that may demand the oscillator
    localparam int unsigned DEF_N_REQ = 4;

    // State of one gate cell in the oscillator domain
    typedef struct packed {
        logic s1;   // first synchroniser stage
        logic s2;   // second synchroniser stage
    } gate_sync_t;

endpackage

// File: rtl/osc_req_ctrl.sv
module osc_req_ctrl #(
    parameter int unsigned N_REQ = osc_arb_pkg::DEF_N_REQ
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_mode,
    input  logic             run_osc_en,
    input  logic             osc_rdy,
    input  logic [N_REQ-1:0] req,
    input  logic [N_REQ-1:0] wake_frame,
    output logic             osc_en,
    output logic             wakeup,
    output logic [N_REQ-1:0] gate_want
);

    localparam logic [N_REQ-1:0] NONE = '0;

    typedef struct packed {
        logic             osc_en;
        logic             wakeup;
        logic [N_REQ-1:0] want;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop_mode) begin
            // oscillator demand is the OR of all live requests
            st_d.osc_en = |req;
            // a gate is wanted only once the oscillator is stable
            st_d.want   = osc_rdy ? req : NONE;
            // only a requester's own frame can wake the system
            st_d.wakeup = st_q.wakeup | (|(req & wake_frame));
        end else begin
            st_d.osc_en = run_osc_en;
            st_d.want   = NONE;
            st_d.wakeup = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign osc_en    = st_q.osc_en;
    assign wakeup    = st_q.wakeup;
    assign gate_want = st_q.want;

endmodule

// File: rtl/osc_gate_cell.sv
module osc_gate_cell (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic want,
    output logic gclk
);

    import osc_arb_pkg::*;

    gate_sync_t sync_d, sync_q;
    logic       en_d, en_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = want;
        sync_d.s2 = sync_q.s1;
        en_d      = sync_q.s2;
    end

    // bring the enable into the oscillator domain
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // apply it while the oscillator clock is low
    always_ff @(negedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign gclk = osc_clk & en_q;

endmodule

// File: rtl/osc_demand_arbiter.sv
module osc_demand_arbiter #(
    parameter int unsigned N_REQ = osc_arb_pkg::DEF_N_REQ
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_mode,
    input  logic             run_osc_en,
    input  logic             osc_rdy,
    input  logic [N_REQ-1:0] req,
    input  logic [N_REQ-1:0] wake_frame,
    input  logic             osc_clk,
    output logic             osc_en,
    output logic             wakeup,
    output logic [N_REQ-1:0] gclk
);

    logic [N_REQ-1:0] gate_want;

    osc_req_ctrl #(.N_REQ(N_REQ)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_mode  (stop_mode),
        .run_osc_en (run_osc_en),
        .osc_rdy    (osc_rdy),
        .req        (req),
        .wake_frame (wake_frame),
        .osc_en     (osc_en),
        .wakeup     (wakeup),
        .gate_want  (gate_want)
    );

    for (genvar g = 0; g < N_REQ; g++) begin : g_gate
        osc_gate_cell i_cell (
            .osc_clk (osc_clk),
            .rst_n   (rst_n),
            .want    (gate_want[g]),
            .gclk    (gclk[g])
        );
    end

endmodule

// File: rtl/osc_arb_chk.sv
module osc_arb_chk #(
    parameter int unsigned N_REQ = osc_arb_pkg::DEF_N_REQ
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_mode,
    input logic             run_osc_en,
    input logic             osc_rdy,
    input logic [N_REQ-1:0] req,
    input logic [N_REQ-1:0] wake_frame,
    input logic             osc_en,
    input logic             wakeup,
    input logic [N_REQ-1:0] gate_want
);

    // R2
    demand_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && (|req)) |=> osc_en);

    // R3
    demand_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && !(|req)) |=> !osc_en);

    // R9
    run_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |=> (osc_en == $past(run_osc_en)));

    // R9
    run_no_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |=> (gate_want == '0));

    // R7
    wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && (|(req & wake_frame))) |=> wakeup);

    // R7
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && wakeup) |=> wakeup);

    // R8
    wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |=> !wakeup);

    // R5
    rdy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_rdy |=> (gate_want == '0));

    for (genvar g = 0; g < N_REQ; g++) begin : g_bit
        // R4
        want_only_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req[g] |=> !gate_want[g]);
        // R4
        want_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_mode && osc_rdy && req[g]) |=> gate_want[g]);
    end

endmodule

bind osc_demand_arbiter osc_arb_chk #(.N_REQ(N_REQ)) i_osc_arb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_mode  (stop_mode),
    .run_osc_en (run_osc_en),
    .osc_rdy    (osc_rdy),
    .req        (req),
    .wake_frame (wake_frame),
    .osc_en     (osc_en),
    .wakeup     (wakeup),
    .gate_want  (gate_want)
);

// File: tb/test_osc_demand_arbiter.sv
`timescale 1ns/1ps
module test_osc_demand_arbiter;

    localparam int N = 4;
    localparam real OSC_HALF = 3.0;

    logic         clk = 1'b0;
    logic         osc_clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_mode = 1'b0;
    logic         run_osc_en = 1'b0;
    logic         osc_rdy = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] wake_frame = '0;
    logic         osc_en;
    logic         wakeup;
    logic [N-1:0] gclk;

    int n_chk = 0;
    int n_fail = 0;
    int pulses [N];
    int bad_width = 0;
    realtime rise_t [N];
    logic [N-1:0] gprev = '0;

    always #10 clk = ~clk;
    always #(OSC_HALF) osc_clk = ~osc_clk;

    osc_demand_arbiter #(.N_REQ(N)) i_osc_demand_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_mode  (stop_mode),
        .run_osc_en (run_osc_en),
        .osc_rdy    (osc_rdy),
        .req        (req),
        .wake_frame (wake_frame),
        .osc_clk    (osc_clk),
        .osc_en     (osc_en),
        .wakeup     (wakeup),
        .gclk       (gclk)
    );

    // pulse counter and width monitor on the gated clocks
    always @(gclk) begin
        for (int i = 0; i < N; i++) begin
            if (gclk[i] && !gprev[i]) begin
                rise_t[i] = $realtime;
                pulses[i]++;
            end else if (!gclk[i] && gprev[i]) begin
                if ((($realtime - rise_t[i]) - OSC_HALF) > 0.01 ||
                    (OSC_HALF - ($realtime - rise_t[i])) > 0.01)
                    bad_width++;
            end
        end
        gprev = gclk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        for (int i = 0; i < N; i++) pulses[i] = 0;
    endtask

    // let gate enables cross into the oscillator domain, then count a window
    task automatic window();
        cyc(3);
        clear_counts();
        cyc(5);
    endtask

    task automatic t_reset();
        cyc(2);
        chk(osc_en == 1'b0, "R1 osc_en", int'(osc_en), 0);
        chk(wakeup == 1'b0, "R1 wakeup", int'(wakeup), 0);
        chk(gclk == '0, "R1 gclk", int'(gclk), 0);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_single();
        stop_mode = 1'b1;
        osc_rdy = 1'b1;
        req = 4'b0010;
        cyc(1);
        chk(osc_en == 1'b1, "R2 osc_en rise", int'(osc_en), 1);
        window();
        chk(pulses[1] > 0, "R4 requester 1 clocked", pulses[1], 1);
        chk(pulses[0] == 0 && pulses[2] == 0 && pulses[3] == 0,
            "R4 others idle", pulses[0] + pulses[2] + pulses[3], 0);
    endtask

    task automatic t_pair_release();
        req = 4'b1010;
        window();
        chk(pulses[1] > 0 && pulses[3] > 0, "R4 both clocked", pulses[3], 1);
        chk(pulses[0] == 0 && pulses[2] == 0, "R4 pair others idle",
            pulses[0] + pulses[2], 0);
        req = 4'b1000;
        cyc(1);
        chk(osc_en == 1'b1, "R3 held with one left", int'(osc_en), 1);
        window();
        chk(pulses[1] == 0 && pulses[3] > 0, "R4 released gate closed", pulses[1], 0);
        req = 4'b0000;
        cyc(1);
        chk(osc_en == 1'b0, "R3 off after last release", int'(osc_en), 0);
        window();
        chk(pulses[3] == 0, "R3 no clock after release", pulses[3], 0);
    endtask

    task automatic t_not_ready();
        osc_rdy = 1'b0;
        req = 4'b0101;
        cyc(1);
        chk(osc_en == 1'b1, "R2 osc_en while not ready", int'(osc_en), 1);
        window();
        chk(pulses[0] == 0 && pulses[2] == 0, "R5 no clock before ready",
            pulses[0] + pulses[2], 0);
        osc_rdy = 1'b1;
        window();
        chk(pulses[0] > 0 && pulses[2] > 0, "R5 clock after ready", pulses[0], 1);
        req = '0;
        cyc(4);
    endtask

    task automatic t_wake();
        req = 4'b0001;
        wake_frame = 4'b0100;
        cyc(1);
        wake_frame = '0;
        chk(wakeup == 1'b0, "R7 non-requester frame ignored", int'(wakeup), 0);
        wake_frame = 4'b0001;
        cyc(1);
        wake_frame = '0;
        chk(wakeup == 1'b1, "R7 wakeup set", int'(wakeup), 1);
        req = '0;
        cyc(3);
        chk(wakeup == 1'b1, "R7 wakeup held", int'(wakeup), 1);
        stop_mode = 1'b0;
        cyc(1);
        chk(wakeup == 1'b0, "R8 wakeup cleared", int'(wakeup), 0);
    endtask

    task automatic t_run();
        run_osc_en = 1'b0;
        req = 4'b1111;
        wake_frame = 4'b1111;
        cyc(1);
        wake_frame = '0;
        chk(osc_en == 1'b0, "R9 request ignored in run", int'(osc_en), 0);
        chk(wakeup == 1'b0, "R9 wake ignored in run", int'(wakeup), 0);
        window();
        chk(pulses[0] + pulses[1] + pulses[2] + pulses[3] == 0, "R9 gates closed in run",
            pulses[0] + pulses[1] + pulses[2] + pulses[3], 0);
        run_osc_en = 1'b1;
        req = '0;
        cyc(1);
        chk(osc_en == 1'b1, "R9 follows run setting", int'(osc_en), 1);
        run_osc_en = 1'b0;
        cyc(1);
        chk(osc_en == 1'b0, "R9 follows run setting off", int'(osc_en), 0);
    endtask

    task automatic finish_run();
        chk(bad_width == 0, "R6 gated pulse width", bad_width, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < N; i++) pulses[i] = 0;
        t_reset();
        t_single();
        t_pair_release();
        t_not_ready();
        t_wake();
        t_run();
        finish_run();
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule